// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block keeps the request, in-service and trigger-mode state for a 256-entry interrupt vector space. Fixed-mode requests arrive as a strobe with an 8-bit vector and a level/edge flag. The block sets the vector's request bit and records its trigger mode in a per-vector bitmap. From a programmable task priority and the most urgent vector in service, it derives a processor priority. It offers the core the most urgent pending vector whose priority class lies strictly above that processor priority.

When the core acknowledges, the offered vector moves from requested to in-service. When the core signals end-of-interrupt, the block retires the highest in-service vector. One cycle later it reports the retired vector and whether it had been accepted as level or edge triggered, so that an upstream routing block can release a level source. Each vector is held at word `vec[7:5]`, bit `vec[4:0]` of its bitmap. Register-bus decoding, timers and destination routing belong to other blocks.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous reset clears all three bitmaps and the task priority. After it, `irq_pending` is 0 and `ppr` is 0x00.
- R2: A vector `v` is stored at word `v[7:5]`, bit `v[4:0]`. Every vector from 0x00 to 0xFF, including those on word boundaries, is recorded and offered with its own number.
- R3: `ppr` equals the task priority when task_priority[7:4] is greater than or equal to the class (bits [7:4]) of the highest in-service vector. Otherwise it equals that vector with bits [3:0] cleared. With nothing in service, the class taken is 0.
- R4: `irq_pending` is 1 only when the highest requested vector `h` satisfies `(h & 0xF0) > ppr`, strictly. `irq_vector` then equals `h`.
- R5: An enabled request for a vector whose request bit is clear sets that bit and pulses `req_taken` on the next cycle. If the bit is already set, the request is merged: `req_merged` pulses instead, and the request bitmap is unchanged.
- R6: The block is enabled only when both `hw_en` and `sw_en` are 1. While either is 0, requests leave no state and no pulse, and `irq_pending` is 0.
- R7: `ack` while `irq_pending` is 1 sets the in-service bit of `irq_vector`, clears its request bit and updates `ppr` on the next cycle. `ack` while `irq_pending` is 0 has no effect.
- R8: `eoi` clears the highest set in-service bit and updates `ppr`. On the next cycle it pulses `eoi_valid` with `eoi_vector` equal to that vector.
- R9: Every enabled request, merged or not, sets the vector's trigger bit when `req_level` is 1 and clears it when `req_level` is 0. On `eoi`, `eoi_level` reports that bit for the retired vector, and the bit is cleared. A level request in the same cycle as `eoi` for the same vector wins and leaves the bit set.
- R10: `eoi` with no vector in service changes nothing and produces no `eoi_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| req_valid | input | 1 | Request strobe |
| req_vector | input | VEC_W | Requested vector |
| req_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | VEC_W | Task priority write value |
| ack | input | 1 | Core acknowledges the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_pending | output | 1 | A vector is offered to the core |
| irq_vector | output | VEC_W | Offered vector |
| ppr | output | VEC_W | Current processor priority |
| req_taken | output | 1 | Previous-cycle request was recorded |
| req_merged | output | 1 | Previous-cycle request found its bit already set |
| eoi_valid | output | 1 | Previous-cycle end-of-interrupt retired a vector |
| eoi_vector | output | VEC_W | Retired vector |
| eoi_level | output | 1 | Retired vector was level triggered |

## Verification
Several rules are checked by assertions on every cycle. A merged request leaves its request bit set. A request seen while disabled yields no pulse. An acknowledge moves the offered vector into service. An end-of-interrupt reports and clears the vector that was highest in service. An end-of-interrupt with nothing in service stays silent. Other behaviour depends on what is stored in the bitmaps and can only be shown by scenarios. These include the exact priority arithmetic at the equal-class boundary, the strict comparison for offering, trigger-mode recovery after a merged edge request, word-boundary vectors, and the state that survives a disable and re-enable.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned VEC_BITS  = 8;
  localparam int unsigned CLASS_LSB = 4;
  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [1:0] {EV_TAKEN, EV_MERGED, EV_RETIRE} ev_kind_e;
endpackage

// File: rtl/irq_find_top.sv
module irq_find_top #(
  parameter int unsigned VEC_W  = irq_prio_pkg::VEC_BITS,
  parameter int unsigned WORD_W = irq_prio_pkg::WORD_BITS
) (
  input  logic [(1<<VEC_W)-1:0] bits,
  output logic                  hit,
  output logic [VEC_W-1:0]      idx
);
  localparam int unsigned NUM    = 1 << VEC_W;
  localparam int unsigned NWORDS = NUM / WORD_W;
  localparam int unsigned BIT_W  = $clog2(WORD_W);

  logic [NWORDS-1:0] word_hit;
  logic [BIT_W-1:0]  word_pos [NWORDS];

  // first level: highest set bit inside each word
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [BIT_W-1:0] pos;
    always_comb begin
      pos = '0;
      for (int b = 0; b < WORD_W; b++)
        if (bits[w*WORD_W + b]) pos = BIT_W'(b);
    end
    assign word_hit[w] = |bits[w*WORD_W +: WORD_W];
    assign word_pos[w] = pos;
  end

  // second level: highest word that holds any bit
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int w = 0; w < NWORDS; w++)
      if (word_hit[w]) begin
        hit = 1'b1;
        idx = VEC_W'(w * WORD_W) | VEC_W'(word_pos[w]);
      end
  end
endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
  parameter int unsigned NUM = 256
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] set_mask,
  input  logic [NUM-1:0] clr_mask,
  output logic [NUM-1:0] q
);
  // a bit in both masks ends set
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/irq_ppr_calc.sv
module irq_ppr_calc #(
  parameter int unsigned VEC_W     = irq_prio_pkg::VEC_BITS,
  parameter int unsigned CLASS_LSB = irq_prio_pkg::CLASS_LSB
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_hit,
  input  logic [VEC_W-1:0] isr_top,
  output logic [VEC_W-1:0] ppr
);
  localparam int unsigned CLS_W = VEC_W - CLASS_LSB;

  logic [CLS_W-1:0] isr_cls;

  always_comb begin
    isr_cls = isr_hit ? isr_top[VEC_W-1:CLASS_LSB] : '0;
    if (tpr[VEC_W-1:CLASS_LSB] >= isr_cls) ppr = tpr;
    else                                   ppr = {isr_cls, {CLASS_LSB{1'b0}}};
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned VEC_W     = irq_prio_pkg::VEC_BITS,
  parameter int unsigned WORD_W    = irq_prio_pkg::WORD_BITS,
  parameter int unsigned CLASS_LSB = irq_prio_pkg::CLASS_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_en,
  input  logic             sw_en,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vector,
  input  logic             req_level,
  input  logic             tpr_we,
  input  logic [VEC_W-1:0] tpr_wdata,
  input  logic             ack,
  input  logic             eoi,
  output logic             irq_pending,
  output logic [VEC_W-1:0] irq_vector,
  output logic [VEC_W-1:0] ppr,
  output logic             req_taken,
  output logic             req_merged,
  output logic             eoi_valid,
  output logic [VEC_W-1:0] eoi_vector,
  output logic             eoi_level
);
  localparam int unsigned NUM   = 1 << VEC_W;
  localparam int unsigned BIT_W = $clog2(WORD_W);

  // one-hot position: word v[VEC_W-1:BIT_W], bit v[BIT_W-1:0]
  function automatic logic [NUM-1:0] vec_bit(input logic [VEC_W-1:0] v);
    logic [NUM-1:0] r;
    int unsigned    wrd;
    int unsigned    pos;
    wrd = int'(v >> BIT_W);
    pos = int'(v[BIT_W-1:0]);
    r = '0;
    r[wrd*WORD_W + pos] = 1'b1;
    return r;
  endfunction

  logic [NUM-1:0]   irr_q, isr_q, tmr_q;
  logic [NUM-1:0]   irr_set, irr_clr, isr_set, isr_clr, tmr_set, tmr_clr;
  logic [VEC_W-1:0] tpr_q;
  logic             irr_hit, isr_hit;
  logic [VEC_W-1:0] irr_top, isr_top;
  logic             enabled, req_go, req_old, ack_go, eoi_go;

  irq_find_top #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_irr_top (
    .bits(irr_q), .hit(irr_hit), .idx(irr_top));
  irq_find_top #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_isr_top (
    .bits(isr_q), .hit(isr_hit), .idx(isr_top));

  irq_ppr_calc #(.VEC_W(VEC_W), .CLASS_LSB(CLASS_LSB)) u_ppr (
    .tpr(tpr_q), .isr_hit(isr_hit), .isr_top(isr_top), .ppr(ppr));

  assign enabled     = hw_en & sw_en;
  assign irq_vector  = irr_top;
  assign irq_pending = enabled && irr_hit &&
                       ({irr_top[VEC_W-1:CLASS_LSB], {CLASS_LSB{1'b0}}} > ppr);

  assign req_go = req_valid & enabled;
  assign req_old = irr_q[req_vector];
  assign ack_go = ack & irq_pending;
  assign eoi_go = eoi & isr_hit;

  always_comb begin
    irr_set = (req_go && !req_old) ? vec_bit(req_vector) : '0;
    irr_clr = ack_go ? vec_bit(irr_top) : '0;
    isr_set = irr_clr;
    isr_clr = eoi_go ? vec_bit(isr_top) : '0;
    tmr_set = (req_go && req_level) ? vec_bit(req_vector) : '0;
    tmr_clr = ((req_go && !req_level) ? vec_bit(req_vector) : '0) | isr_clr;
  end

  irq_vec_bank #(.NUM(NUM)) u_irr (
    .clk(clk), .rst(rst), .set_mask(irr_set), .clr_mask(irr_clr), .q(irr_q));
  irq_vec_bank #(.NUM(NUM)) u_isr (
    .clk(clk), .rst(rst), .set_mask(isr_set), .clr_mask(isr_clr), .q(isr_q));
  irq_vec_bank #(.NUM(NUM)) u_tmr (
    .clk(clk), .rst(rst), .set_mask(tmr_set), .clr_mask(tmr_clr), .q(tmr_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      tpr_q      <= '0;
      req_taken  <= 1'b0;
      req_merged <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
      eoi_level  <= 1'b0;
    end else begin
      if (tpr_we) tpr_q <= tpr_wdata;
      req_taken  <= req_go & ~req_old;
      req_merged <= req_go & req_old;
      eoi_valid  <= eoi_go;
      if (eoi_go) begin
        eoi_vector <= isr_top;
        eoi_level  <= tmr_q[isr_top];
      end
    end
  end

  // R5: a merged request leaves the request bit standing
  assert_merge_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hw_en && sw_en && irr_q[req_vector] && !ack)
      |=> (req_merged && irr_q[$past(req_vector)]));

  // R6: nothing is recorded while disabled
  assert_off_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(hw_en && sw_en)) |=> (!req_taken && !req_merged));

  // R7: acknowledge moves the offered vector into service
  assert_ack_moves_R7: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_pending)
      |=> (isr_q[$past(irq_vector)] && !irr_q[$past(irq_vector)]));

  // R8: end-of-interrupt retires and reports the top in-service vector
  assert_eoi_reports_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi && isr_hit)
      |=> (eoi_valid && eoi_vector == $past(isr_top) && !isr_q[$past(isr_top)]));

  // R10: end-of-interrupt with nothing in service is silent
  assert_eoi_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (eoi && !isr_hit) |=> !eoi_valid);
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  import irq_prio_pkg::*;

  typedef struct {
    ev_kind_e   kind;
    logic [7:0] vec;
    logic       lvl;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hw_en = 1'b0, sw_en = 1'b0;
  logic       req_valid = 1'b0, req_level = 1'b0;
  logic [7:0] req_vector = '0;
  logic       tpr_we = 1'b0;
  logic [7:0] tpr_wdata = '0;
  logic       ack = 1'b0, eoi = 1'b0;
  logic       irq_pending, req_taken, req_merged, eoi_valid, eoi_level;
  logic [7:0] irq_vector, ppr, eoi_vector;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";
  exp_t  exp_q[$];

  always #10 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst(rst), .hw_en(hw_en), .sw_en(sw_en),
    .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ack(ack), .eoi(eoi),
    .irq_pending(irq_pending), .irq_vector(irq_vector), .ppr(ppr),
    .req_taken(req_taken), .req_merged(req_merged),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard whenever the block reports an event
  always @(negedge clk) begin
    if (!rst && (req_taken || req_merged || eoi_valid)) begin
      if (exp_q.size() == 0) begin
        chk({cur_tag, " unexpected event"}, 32'(req_taken | (req_merged << 1) | (eoi_valid << 2)), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " taken"},  32'(req_taken),  32'(e.kind == EV_TAKEN));
        chk({e.tag, " merged"}, 32'(req_merged), 32'(e.kind == EV_MERGED));
        chk({e.tag, " retire"}, 32'(eoi_valid),  32'(e.kind == EV_RETIRE));
        if (e.kind == EV_RETIRE) begin
          chk({e.tag, " retire vector"}, 32'(eoi_vector), 32'(e.vec));
          chk({e.tag, " retire level"},  32'(eoi_level),  32'(e.lvl));
        end
      end
    end
  end

  task automatic do_req(input logic [7:0] v, input logic lvl, input int kind, input string tag);
    cur_tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_vector = v; req_level = lvl;
    if (kind >= 0) exp_q.push_back('{ev_kind_e'(kind), v, lvl, tag});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_tpr(input logic [7:0] v);
    @(negedge clk);
    tpr_we = 1'b1; tpr_wdata = v;
    @(negedge clk);
    tpr_we = 1'b0;
  endtask

  task automatic do_ack(input string tag);
    cur_tag = tag;
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_eoi(input bit expect_ev, input logic [7:0] v, input logic lvl, input string tag);
    cur_tag = tag;
    @(negedge clk);
    eoi = 1'b1;
    if (expect_ev) exp_q.push_back('{EV_RETIRE, v, lvl, tag});
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic chk_offer(input string tag, input logic p, input logic [7:0] v);
    chk({tag, " pending"}, 32'(irq_pending), 32'(p));
    if (p) chk({tag, " vector"}, 32'(irq_vector), 32'(v));
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pending", 32'(irq_pending), 0);
    chk("R1 ppr", 32'(ppr), 0);
    hw_en = 1'b1; sw_en = 1'b1;
    @(negedge clk);
    chk("R1 empty after enable", 32'(irq_pending), 0);

    do_req(8'h45, 1'b0, EV_TAKEN, "R2");
    chk_offer("R2", 1'b1, 8'h45);
    do_req(8'h45, 1'b0, EV_MERGED, "R5");
    chk_offer("R5", 1'b1, 8'h45);
    do_req(8'hA3, 1'b1, EV_TAKEN, "R4");
    chk_offer("R4 highest", 1'b1, 8'hA3);

    do_tpr(8'hB0);
    chk("R3 tpr B0", 32'(ppr), 32'h B0);
    chk_offer("R4 below tpr", 1'b0, 8'h00);
    do_tpr(8'hA0);
    chk_offer("R4 equal class", 1'b0, 8'h00);
    do_tpr(8'h95);
    chk_offer("R4 above tpr", 1'b1, 8'hA3);
    do_tpr(8'h00);

    do_ack("R7");
    chk("R7 ppr after ack", 32'(ppr), 32'h A0);
    chk_offer("R7 lower class held", 1'b0, 8'h00);
    do_tpr(8'hC7);
    chk("R3 tpr wins", 32'(ppr), 32'h C7);
    do_tpr(8'hA5);
    chk("R3 equal class keeps tpr", 32'(ppr), 32'h A5);
    do_tpr(8'h00);
    chk("R3 isr class", 32'(ppr), 32'h A0);

    do_req(8'hB1, 1'b0, EV_TAKEN, "R4");
    chk_offer("R4 nested", 1'b1, 8'hB1);
    do_ack("R7");
    chk("R7 nested ppr", 32'(ppr), 32'h B0);

    do_eoi(1'b1, 8'hB1, 1'b0, "R8");
    chk("R8 ppr after retire", 32'(ppr), 32'h A0);
    do_eoi(1'b1, 8'hA3, 1'b1, "R9");
    chk("R8 ppr empty", 32'(ppr), 0);
    chk_offer("R8 older offered", 1'b1, 8'h45);

    do_eoi(1'b0, 8'h00, 1'b0, "R10");
    chk("R10 ppr", 32'(ppr), 0);
    chk_offer("R10 offer kept", 1'b1, 8'h45);

    do_ack("R7");
    chk("R7 ppr 40", 32'(ppr), 32'h 40);
    do_req(8'h45, 1'b1, EV_TAKEN, "R9");
    chk_offer("R4 same class held", 1'b0, 8'h00);
    do_eoi(1'b1, 8'h45, 1'b1, "R9");
    chk_offer("R9 re-offer", 1'b1, 8'h45);
    do_req(8'h45, 1'b0, EV_MERGED, "R9");
    do_ack("R9");
    do_eoi(1'b1, 8'h45, 1'b0, "R9");
    chk_offer("R9 drained", 1'b0, 8'h00);

    do_ack("R7");
    do_eoi(1'b0, 8'h00, 1'b0, "R7");
    chk("R7 idle ack ppr", 32'(ppr), 0);

    sw_en = 1'b0;
    do_req(8'h60, 1'b1, -1, "R6");
    @(negedge clk);
    sw_en = 1'b1;
    @(negedge clk);
    chk_offer("R6 nothing kept", 1'b0, 8'h00);
    do_req(8'h70, 1'b0, EV_TAKEN, "R6");
    hw_en = 1'b0;
    @(negedge clk);
    chk_offer("R6 masked offer", 1'b0, 8'h00);
    do_ack("R6");
    hw_en = 1'b1;
    @(negedge clk);
    chk_offer("R6 restored", 1'b1, 8'h70);
    do_ack("R7");
    do_eoi(1'b1, 8'h70, 1'b0, "R8");

    do_req(8'h1F, 1'b0, EV_TAKEN, "R2");
    do_req(8'h20, 1'b0, EV_TAKEN, "R2");
    do_req(8'hFF, 1'b1, EV_TAKEN, "R2");
    do_req(8'hE0, 1'b0, EV_TAKEN, "R2");
    chk_offer("R2 top word", 1'b1, 8'hFF);
    do_ack("R2");
    chk("R2 ppr F0", 32'(ppr), 32'h F0);
    do_eoi(1'b1, 8'hFF, 1'b1, "R2");
    chk_offer("R2 E0", 1'b1, 8'hE0);
    do_ack("R2");
    do_eoi(1'b1, 8'hE0, 1'b0, "R2");
    chk_offer("R2 word start", 1'b1, 8'h20);
    do_ack("R2");
    chk("R2 ppr 20", 32'(ppr), 32'h 20);
    chk_offer("R2 lower word held", 1'b0, 8'h00);
    do_eoi(1'b1, 8'h20, 1'b0, "R2");
    chk_offer("R2 word end", 1'b1, 8'h1F);
    do_ack("R2");
    do_eoi(1'b1, 8'h1F, 1'b0, "R2");
    chk_offer("R2 all clear", 1'b0, 8'h00);

    repeat (3) @(negedge clk);
    chk("R8 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    finish_run();
  end
endmodule